// File: doc/BRIEF.md
# Register-format execute unit

This block is the combinational execute slice for register-format instructions in a single-issue integer pipeline. It takes a 32-bit instruction word and the two source operands the register file has already read. It returns three things: the result, the index of the destination register, and a write enable for the writeback stage. It also gives back the two source indices taken from the word, so the same word can address the register file read ports.

The unit recognises five two-operand functions: wrapping add, wrapping subtract, OR, XOR and NOR. It also recognises three shifts by an immediate amount: left, logical right and arithmetic right. The shifts act on the second operand only and take their distance from the shift-amount field of the word. A word whose major opcode is not zero, or whose function code is not one of these eight, is flagged illegal. An illegal word never writes a register. A legal word aimed at register 0 also never writes.

Top module: `rexec_unit`

## Requirements
- R1: The word splits, from bit 31 down, into opcode [31:26], first source index [25:21], second source index [20:16], destination index [15:11], shift amount [10:6] and function code [5:0]. The unit drives rsIdx, rtIdx and destIdx straight from the three index fields.
- R2: Function code 0x21 gives rsData + rtData modulo 2^32, with no overflow indication.
- R3: Function code 0x23 gives rsData - rtData modulo 2^32, with no overflow indication.
- R4: Function codes 0x25, 0x26 and 0x27 give the bitwise OR, XOR and NOR of rsData and rtData.
- R5: Function code 0x00 shifts rtData left by the shift-amount field and fills with zeros. rsData has no effect on the result.
- R6: Function code 0x02 shifts rtData right by the shift-amount field and fills with zeros.
- R7: Function code 0x03 shifts rtData right by the shift-amount field and fills with copies of rtData bit 31.
- R8: When the opcode is nonzero, or the function code is not one of the eight above, illegalFn is 1, regWrEn is 0 and result is 0.
- R9: For a legal word whose destination index is 0, regWrEn is 0 and illegalFn is 0, while result still carries the computed value.
- R10: For a legal word whose destination index is nonzero, regWrEn is 1 and illegalFn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Register-format instruction word |
| rsData | input | 32 | Value of the first source register |
| rtData | input | 32 | Value of the second source register |
| rsIdx | output | 5 | First source index for the register file |
| rtIdx | output | 5 | Second source index for the register file |
| destIdx | output | 5 | Destination index for writeback |
| result | output | 32 | Computed value, zero for an illegal word |
| regWrEn | output | 1 | Writeback enable |
| illegalFn | output | 1 | Opcode or function code not supported |

## Verification
The assertions assume that the instruction word and both operands hold known values, and they are checked only when no input bit is unknown. They also assume that the source operands belong to the word currently applied. The bench changes all three inputs together on one clock edge and checks the outputs half a period later. It never leaves an input undriven. The stimulus combines directed words with random words. The directed words hit every function code, shift distances of 0 and 31, a negative operand for the arithmetic shift, carry and borrow wraparound, destination index 0 and nonzero opcodes. The random words mix legal and unknown function codes.

// File: rtl/rexec_pkg.sv
package rexec_pkg;
  localparam int OP_W    = 6;
  localparam int IDX_W   = 5;
  localparam int FUNCT_W = 6;

  typedef enum logic [FUNCT_W-1:0] {
    FN_SLL  = 6'h00,
    FN_SRL  = 6'h02,
    FN_SRA  = 6'h03,
    FN_ADDU = 6'h21,
    FN_SUBU = 6'h23,
    FN_OR   = 6'h25,
    FN_XOR  = 6'h26,
    FN_NOR  = 6'h27
  } funct_e;

  typedef enum logic [2:0] {
    SEL_ADD, SEL_SUB, SEL_OR, SEL_XOR, SEL_NOR, SEL_SHIFT
  } aluSel_e;

  typedef struct packed {
    aluSel_e aluSel;
    logic    shiftRight;
    logic    shiftArith;
    logic    legal;
  } ctrlStrobes_t;
endpackage

// File: rtl/rexec_ctrl.sv
module rexec_ctrl
  import rexec_pkg::*;
(
  input  logic [OP_W-1:0]    opField,
  input  logic [FUNCT_W-1:0] functField,
  output ctrlStrobes_t       strobes
);
  always_comb begin
    strobes = '{aluSel: SEL_ADD, shiftRight: 1'b0, shiftArith: 1'b0, legal: 1'b1};
    unique case (functField)
      FN_ADDU: strobes.aluSel = SEL_ADD;
      FN_SUBU: strobes.aluSel = SEL_SUB;
      FN_OR:   strobes.aluSel = SEL_OR;
      FN_XOR:  strobes.aluSel = SEL_XOR;
      FN_NOR:  strobes.aluSel = SEL_NOR;
      FN_SLL:  strobes.aluSel = SEL_SHIFT;
      FN_SRL: begin
        strobes.aluSel     = SEL_SHIFT;
        strobes.shiftRight = 1'b1;
      end
      FN_SRA: begin
        strobes.aluSel     = SEL_SHIFT;
        strobes.shiftRight = 1'b1;
        strobes.shiftArith = 1'b1;
      end
      default: strobes.legal = 1'b0;
    endcase
    if (opField != '0) strobes.legal = 1'b0;
  end
endmodule

// File: rtl/rexec_shifter.sv
module rexec_shifter #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [AMT_W-1:0]  amount,
  input  logic              toRight,
  input  logic              arith,
  output logic [DATA_W-1:0] dataOut
);
  localparam int STAGES = AMT_W;

  function automatic logic [DATA_W-1:0] flipBits(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic              fillBit;
  logic [DATA_W-1:0] stg [0:STAGES];
  logic [DATA_W-1:0] rightOut;

  assign fillBit = toRight & arith & dataIn[DATA_W-1];
  assign stg[0]  = toRight ? dataIn : flipBits(dataIn);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int DIST = 1 << s;
    if (DIST < DATA_W) begin : g_move
      assign stg[s+1] = amount[s] ? {{DIST{fillBit}}, stg[s][DATA_W-1:DIST]} : stg[s];
    end else begin : g_flood
      assign stg[s+1] = amount[s] ? {DATA_W{fillBit}} : stg[s];
    end
  end

  assign rightOut = stg[STAGES];
  assign dataOut  = toRight ? rightOut : flipBits(rightOut);
endmodule

// File: rtl/rexec_dp.sv
module rexec_dp
  import rexec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  shamtField,
  input  logic [DATA_W-1:0] rsData,
  input  logic [DATA_W-1:0] rtData,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] shiftOut;
  logic [DATA_W-1:0] rawOut;

  rexec_shifter #(.DATA_W(DATA_W), .AMT_W(IDX_W)) u_shift (
    .dataIn  (rtData),
    .amount  (shamtField),
    .toRight (strobes.shiftRight),
    .arith   (strobes.shiftArith),
    .dataOut (shiftOut)
  );

  always_comb begin
    unique case (strobes.aluSel)
      SEL_ADD:   rawOut = rsData + rtData;
      SEL_SUB:   rawOut = rsData - rtData;
      SEL_OR:    rawOut = rsData | rtData;
      SEL_XOR:   rawOut = rsData ^ rtData;
      SEL_NOR:   rawOut = ~(rsData | rtData);
      SEL_SHIFT: rawOut = shiftOut;
      default:   rawOut = '0;
    endcase
  end

  assign result = strobes.legal ? rawOut : '0;
endmodule

// File: rtl/rexec_unit.sv
module rexec_unit
  import rexec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       instrWord,
  input  logic [DATA_W-1:0] rsData,
  input  logic [DATA_W-1:0] rtData,
  output logic [IDX_W-1:0]  rsIdx,
  output logic [IDX_W-1:0]  rtIdx,
  output logic [IDX_W-1:0]  destIdx,
  output logic [DATA_W-1:0] result,
  output logic              regWrEn,
  output logic              illegalFn
);
  localparam int FUNCT_LSB = 0;
  localparam int SHAMT_LSB = FUNCT_LSB + FUNCT_W;
  localparam int RD_LSB    = SHAMT_LSB + IDX_W;
  localparam int RT_LSB    = RD_LSB + IDX_W;
  localparam int RS_LSB    = RT_LSB + IDX_W;
  localparam int OP_LSB    = RS_LSB + IDX_W;

  ctrlStrobes_t strobes;

  assign rsIdx   = instrWord[RS_LSB +: IDX_W];
  assign rtIdx   = instrWord[RT_LSB +: IDX_W];
  assign destIdx = instrWord[RD_LSB +: IDX_W];

  rexec_ctrl u_ctrl (
    .opField    (instrWord[OP_LSB +: OP_W]),
    .functField (instrWord[FUNCT_LSB +: FUNCT_W]),
    .strobes    (strobes)
  );

  rexec_dp #(.DATA_W(DATA_W)) u_dp (
    .strobes    (strobes),
    .shamtField (instrWord[SHAMT_LSB +: IDX_W]),
    .rsData     (rsData),
    .rtData     (rtData),
    .result     (result)
  );

  assign illegalFn = ~strobes.legal;
  assign regWrEn   = strobes.legal & (destIdx != '0);
endmodule

// File: rtl/rexec_unit_chk.sv
module rexec_unit_chk (
  input logic [31:0] instrWord,
  input logic [31:0] rsData,
  input logic [31:0] rtData,
  input logic [4:0]  rsIdx,
  input logic [4:0]  rtIdx,
  input logic [4:0]  destIdx,
  input logic [31:0] result,
  input logic        regWrEn,
  input logic        illegalFn
);
  logic known;
  logic isR;
  assign known = !$isunknown({instrWord, rsData, rtData});
  assign isR   = (instrWord[31:26] == 6'd0);

  always_comb begin
    if (known) begin
      // R1
      field_split_chk: assert ({rsIdx, rtIdx, destIdx} == instrWord[25:11]);
      // R3
      subu_wrap_chk: assert (!(isR && instrWord[5:0] == 6'h23) || (result + rtData == rsData));
      // R4
      nor_chk: assert (!(isR && instrWord[5:0] == 6'h27) ||
                       (((result & (rsData | rtData)) == 32'd0) && ((result | rsData | rtData) == 32'hFFFF_FFFF)));
      // R7
      sra_sign_chk: assert (!(isR && instrWord[5:0] == 6'h03 && rtData[31]) || result[31]);
      // R8
      illegal_gate_chk: assert (!illegalFn || (!regWrEn && result == 32'd0));
      // R8
      bad_op_chk: assert (isR || illegalFn);
      // R9
      zero_dest_chk: assert (destIdx != 5'd0 || !regWrEn);
      // R10
      legal_write_chk: assert (illegalFn || destIdx == 5'd0 || regWrEn);
    end
  end
endmodule

bind rexec_unit rexec_unit_chk u_chk (
  .instrWord (instrWord),
  .rsData    (rsData),
  .rtData    (rtData),
  .rsIdx     (rsIdx),
  .rtIdx     (rtIdx),
  .destIdx   (destIdx),
  .result    (result),
  .regWrEn   (regWrEn),
  .illegalFn (illegalFn)
);

// File: tb/sim_rexec_unit.sv
`timescale 1ns/1ps
module sim_rexec_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instrWord = 32'd0;
  logic [31:0] rsData = 32'd0;
  logic [31:0] rtData = 32'd0;
  logic [4:0]  rsIdx, rtIdx, destIdx;
  logic [31:0] result;
  logic        regWrEn, illegalFn;

  int checks = 0;
  int fails  = 0;

  rexec_unit u0 (
    .instrWord (instrWord), .rsData (rsData), .rtData (rtData),
    .rsIdx (rsIdx), .rtIdx (rtIdx), .destIdx (destIdx),
    .result (result), .regWrEn (regWrEn), .illegalFn (illegalFn)
  );

  function automatic logic [31:0] mkWord(input int op, input int rs, input int rt,
                                         input int rd, input int sh, input int fn);
    return {op[5:0], rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  // behavioural reference: returns legal flag, fills expected value
  function automatic bit model(input logic [31:0] w, input logic [31:0] a,
                               input logic [31:0] b, output logic [31:0] val);
    int sh;
    longint sa;
    sh = int'(w[10:6]);
    val = 32'd0;
    if (w[31:26] != 6'd0) return 1'b0;
    case (int'(w[5:0]))
      'h21: val = 32'((longint'(a) + longint'(b)) % (64'sd1 << 32));
      'h23: val = 32'((longint'(a) - longint'(b) + (64'sd1 << 32)) % (64'sd1 << 32));
      'h25: val = a | b;
      'h26: val = a ^ b;
      'h27: val = ~(a | b);
      'h00: val = 32'(longint'(b) * (64'sd1 << sh));
      'h02: val = 32'(longint'(b) / (64'sd1 << sh));
      'h03: begin
        sa = b[31] ? longint'(b) - (64'sd1 << 32) : longint'(b);
        val = 32'(sa >>> sh);
      end
      default: return 1'b0;
    endcase
    return 1'b1;
  endfunction

  function automatic string tagFor(input logic [31:0] w);
    if (w[31:26] != 0) return "R8";
    case (int'(w[5:0]))
      'h21: return "R2";
      'h23: return "R3";
      'h25, 'h26, 'h27: return "R4";
      'h00: return "R5";
      'h02: return "R6";
      'h03: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] ev;
    bit legal;
    @(posedge clk);
    instrWord <= w; rsData <= a; rtData <= b;
    @(negedge clk);
    legal = model(w, a, b, ev);
    cmp("R1", "rsIdx", 32'(rsIdx), 32'(w[25:21]));
    cmp("R1", "rtIdx", 32'(rtIdx), 32'(w[20:16]));
    cmp("R1", "destIdx", 32'(destIdx), 32'(w[15:11]));
    cmp(tagFor(w), "result", result, ev);
    cmp(legal ? "R10" : "R8", "illegalFn", 32'(illegalFn), 32'(!legal));
    if (legal && w[15:11] == 5'd0) cmp("R9", "regWrEn", 32'(regWrEn), 32'd0);
    else cmp(legal ? "R10" : "R8", "regWrEn", 32'(regWrEn), 32'(legal));
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // idle word 0 is sll r0,r0,0: legal, no write
    @(negedge clk);
    cmp("R9", "idle regWrEn", 32'(regWrEn), 32'd0);
    cmp("R9", "idle illegalFn", 32'(illegalFn), 32'd0);
    // R2 wraparound and plain add
    apply(mkWord(0, 3, 4, 5, 0, 'h21), 32'hFFFF_FFFF, 32'd2);
    apply(mkWord(0, 1, 2, 31, 0, 'h21), 32'd100, 32'd23);
    // R3 borrow wrap
    apply(mkWord(0, 6, 7, 8, 0, 'h23), 32'd1, 32'd2);
    apply(mkWord(0, 6, 7, 8, 0, 'h23), 32'h8000_0000, 32'd1);
    // R4 logic
    apply(mkWord(0, 9, 10, 11, 0, 'h25), 32'hF0F0_0000, 32'h0F0F_00FF);
    apply(mkWord(0, 9, 10, 11, 0, 'h26), 32'hAAAA_5555, 32'hFFFF_0000);
    apply(mkWord(0, 9, 10, 11, 0, 'h27), 32'h1234_0000, 32'h0000_5678);
    // R5 shift left, rs must not matter
    apply(mkWord(0, 12, 13, 14, 6, 'h00), 32'hDEAD_BEEF, 32'd3);
    apply(mkWord(0, 12, 13, 14, 6, 'h00), 32'd0, 32'd3);
    apply(mkWord(0, 12, 13, 14, 31, 'h00), 32'd0, 32'hFFFF_FFFF);
    // R6 logical right
    apply(mkWord(0, 1, 2, 3, 4, 'h02), 32'd0, 32'h8000_00F0);
    apply(mkWord(0, 1, 2, 3, 31, 'h02), 32'd5, 32'h8000_0000);
    apply(mkWord(0, 1, 2, 3, 0, 'h02), 32'd5, 32'h1234_5678);
    // R7 arithmetic right, negative and positive
    apply(mkWord(0, 1, 2, 3, 4, 'h03), 32'd0, 32'h8000_00F0);
    apply(mkWord(0, 1, 2, 3, 31, 'h03), 32'd0, 32'h8000_0000);
    apply(mkWord(0, 1, 2, 3, 8, 'h03), 32'd0, 32'h7000_0000);
    // R8 unknown funct and nonzero op
    apply(mkWord(0, 1, 2, 3, 0, 'h20), 32'd7, 32'd9);
    apply(mkWord(0, 1, 2, 3, 0, 'h3F), 32'd7, 32'd9);
    apply(mkWord(8, 1, 2, 3, 0, 'h21), 32'd7, 32'd9);
    apply(mkWord(63, 1, 2, 3, 0, 'h25), 32'd7, 32'd9);
    // R9 destination zero still computes
    apply(mkWord(0, 4, 5, 0, 0, 'h21), 32'd10, 32'd20);
    apply(mkWord(0, 4, 5, 0, 3, 'h03), 32'd0, 32'hF000_0000);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int fsel;
      int fn;
      fsel = int'($urandom_range(0, 9));
      case (fsel)
        0: fn = 'h21; 1: fn = 'h23; 2: fn = 'h25; 3: fn = 'h26; 4: fn = 'h27;
        5: fn = 'h00; 6: fn = 'h02; 7: fn = 'h03;
        default: fn = int'($urandom_range(0, 63));
      endcase
      apply(mkWord(($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 63)) : 0,
                   int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                   int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), fn),
            $urandom, $urandom);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule